// File: doc/BRIEF.md
# Size-selectable unsigned multiply unit

This execution unit multiplies an implied accumulator value by a second operand, both taken as unsigned, for an operand size of 8, 16, 32 or 64 bits. A start strobe captures the size, the accumulator value and the source operand. A radix-2 shift-add engine then retires one multiplier bit per clock cycle. After that, a registered output stage presents the double-width product together with its write enables and the carry/overflow pair for a single cycle.

Where the product goes depends on the size. For an 8-bit operation, the whole 16-bit product is one value written into the accumulator. For the larger sizes, the product is split into a low half for the accumulator and a high half for the data register. The carry and overflow outputs both report whether the high half of the product is non-zero. A validity mask tells the consumer that these two are the only flags the unit defines. Decoding, register-file access and memory operands are handled elsewhere; the unit only sees values and strobes.

Top module: `mul_unsigned_unit`

## Requirements
- R1: `size_sel_i` is decoded as 00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits (the default size). `wide_i` = 1 promotes the 32-bit choices to 64 bits and has no effect when 8 or 16 bits is selected.
- R2: Both factors are unsigned. Bits of `acc_i` and `src_i` above the selected size do not affect any output.
- R3: For 8 bits, `acc_o[15:0]` is the complete 16-bit product, `acc_o[63:16]` is zero, `dreg_we_o` stays 0 and `dreg_o` is zero.
- R4: For 16, 32 and 64 bits, `acc_o` holds the low half of the product and `dreg_o` holds the high half, each zero-extended to 64 bits, and both `acc_we_o` and `dreg_we_o` are 1.
- R5: During done, `cf_o` and `of_o` are both 1 when the high half of the product (bits 15:8 for the 8-bit size) is non-zero, and both 0 otherwise.
- R6: With start sampled at clock edge 0, `done_o` is high for exactly one cycle, the cycle that follows edge N+1, where N is the operand size in bits. The write enables are high only while `done_o` is high.
- R7: A start strobe that arrives while a multiplication is in progress is ignored. The running operation keeps its timing and its result.
- R8: Operands and size are captured on the start edge. Changes on the inputs after that edge do not alter the result in progress.
- R9: `flags_vld_o` is 6'b100001 while `done_o` is high and 0 otherwise. Bit 0 marks carry as valid, bit 5 marks overflow as valid, and bits 1 to 4 (parity, auxiliary, zero, sign) are marked undefined.
- R10: While `rst` is high at a clock edge, all outputs go to zero and any operation in progress is abandoned with no done pulse.
- R11: Between done pulses, `acc_o`, `dreg_o`, `cf_o` and `of_o` keep the values of the last completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| size_sel_i | input | 2 | Operand size select |
| wide_i | input | 1 | Promote the default size to 64 bits |
| acc_i | input | 64 | Accumulator operand (first factor) |
| src_i | input | 64 | Source operand (second factor) |
| acc_o | output | 64 | Accumulator result (low half, or whole 16-bit product) |
| dreg_o | output | 64 | Data-register result (high half) |
| acc_we_o | output | 1 | Accumulator write enable |
| dreg_we_o | output | 1 | Data-register write enable |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| flags_vld_o | output | 6 | Mask of flag bits that carry defined values |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `rst` is synchronous, that all inputs carry known values after reset, and that `start_i` matters only when the engine is idle. The stimulus drives every input on the falling clock edge and keeps it known from time zero. It holds `start_i` for a single cycle, except where it deliberately raises the strobe again during a running operation. Operand bits above the selected size are filled with non-zero values so that the masking is exercised, and one reset is applied in the middle of an operation to show that the pending result is dropped.

// File: rtl/mul_pkg.sv
package mul_pkg;

  localparam int MAX_W  = 64;
  localparam int PROD_W = 2 * MAX_W;
  localparam int CNT_W  = $clog2(MAX_W + 1);

  typedef enum logic [1:0] {
    OPSZ_B = 2'd0,
    OPSZ_W = 2'd1,
    OPSZ_D = 2'd2,
    OPSZ_Q = 2'd3
  } opsz_e;

  localparam int FLG_N     = 6;
  localparam int FLG_CARRY = 0;
  localparam int FLG_PAR   = 1;
  localparam int FLG_AUX   = 2;
  localparam int FLG_ZERO  = 3;
  localparam int FLG_SIGN  = 4;
  localparam int FLG_OVF   = 5;

  function automatic int unsigned opsz_bits(opsz_e s);
    return 32'd8 << s;
  endfunction

endpackage

// File: rtl/mul_size_decode.sv
module mul_size_decode
  import mul_pkg::*;
#(
  parameter int DATA_W = MAX_W,
  parameter int CW     = CNT_W
) (
  input  logic [1:0]        size_sel_i,
  input  logic              wide_i,
  output opsz_e             size_o,
  output logic [CW-1:0]     bits_o,
  output logic [DATA_W-1:0] mask_o
);

  always_comb begin
    unique case (size_sel_i)
      2'b00:   size_o = OPSZ_B;
      2'b01:   size_o = OPSZ_W;
      default: size_o = wide_i ? OPSZ_Q : OPSZ_D;
    endcase
  end

  always_comb begin
    bits_o = CW'(opsz_bits(size_o));
    mask_o = {DATA_W{1'b1}} >> (DATA_W - int'(opsz_bits(size_o)));
  end

endmodule

// File: rtl/mul_shift_add_core.sv
module mul_shift_add_core
  import mul_pkg::*;
#(
  parameter int DATA_W = MAX_W,
  parameter int CW     = CNT_W,
  localparam int PW    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  opsz_e             size_i,
  input  logic [CW-1:0]     bits_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              fin_o,
  output opsz_e             size_o,
  output logic [PW-1:0]     prod_o
);

  logic              busy_q;
  logic [CW-1:0]     cnt_q;
  logic [PW-1:0]     mcand_q;
  logic [DATA_W-1:0] mplier_q;
  logic [PW-1:0]     prod_q;
  opsz_e             size_q;
  logic              fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
      size_q   <= OPSZ_B;
      fin_q    <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q   <= 1'b1;
        cnt_q    <= bits_i;
        mcand_q  <= {{DATA_W{1'b0}}, acc_i & mask_i};
        mplier_q <= src_i & mask_i;
        prod_q   <= '0;
        size_q   <= size_i;
      end else if (busy_q) begin
        if (mplier_q[0]) begin
          prod_q <= prod_q + mcand_q;
        end
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign fin_o  = fin_q;
  assign size_o = size_q;
  assign prod_o = prod_q;

  // R7: a start strobe during a run leaves the step counter advancing
  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R6: the counter stays inside the operand width while running
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0 && int'(cnt_q) <= DATA_W));

  // R2: masked multiplier has no bits left once all steps are done
  a_r2_mplier_drained: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> (mplier_q == '0));

  // R6: finishing clears busy
  a_r6_fin_idle: assert property (@(posedge clk) disable iff (rst)
    fin_q |-> !busy_q);

endmodule

// File: rtl/mul_result_pack.sv
module mul_result_pack
  import mul_pkg::*;
#(
  parameter int DATA_W = MAX_W,
  localparam int PW    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin_i,
  input  opsz_e             size_i,
  input  logic [PW-1:0]     prod_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] dreg_o,
  output logic              acc_we_o,
  output logic              dreg_we_o,
  output logic              cf_o,
  output logic              of_o,
  output logic [FLG_N-1:0]  flags_vld_o,
  output logic              done_o
);

  logic [FLG_N-1:0]  def_mask;
  logic [DATA_W-1:0] lo_d, hi_d;
  logic              hi_nz_d;
  logic [DATA_W-1:0] half_mask;
  opsz_e             size_q;

  for (genvar g = 0; g < FLG_N; g++) begin : g_flag_mask
    assign def_mask[g] = (g == FLG_CARRY) || (g == FLG_OVF);
  end

  always_comb begin
    half_mask = {DATA_W{1'b1}} >> (DATA_W - int'(opsz_bits(size_i)));
    if (size_i == OPSZ_B) begin
      lo_d    = {{(DATA_W-16){1'b0}}, prod_i[15:0]};
      hi_d    = '0;
      hi_nz_d = |prod_i[15:8];
    end else begin
      lo_d    = prod_i[DATA_W-1:0] & half_mask;
      hi_d    = DATA_W'(prod_i >> opsz_bits(size_i)) & half_mask;
      hi_nz_d = |hi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o       <= '0;
      dreg_o      <= '0;
      acc_we_o    <= 1'b0;
      dreg_we_o   <= 1'b0;
      cf_o        <= 1'b0;
      of_o        <= 1'b0;
      flags_vld_o <= '0;
      done_o      <= 1'b0;
      size_q      <= OPSZ_B;
    end else begin
      acc_we_o    <= 1'b0;
      dreg_we_o   <= 1'b0;
      flags_vld_o <= '0;
      done_o      <= 1'b0;
      if (fin_i) begin
        acc_o       <= lo_d;
        dreg_o      <= hi_d;
        acc_we_o    <= 1'b1;
        dreg_we_o   <= (size_i != OPSZ_B);
        cf_o        <= hi_nz_d;
        of_o        <= hi_nz_d;
        flags_vld_o <= def_mask;
        done_o      <= 1'b1;
        size_q      <= size_i;
      end
    end
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: write enables appear only with done
  a_r6_we_with_done: assert property (@(posedge clk) disable iff (rst)
    (acc_we_o || dreg_we_o) |-> done_o);

  // R3: byte result never touches the data register and stays 16 bits wide
  a_r3_byte_single_write: assert property (@(posedge clk) disable iff (rst)
    (done_o && size_q == OPSZ_B) |-> (!dreg_we_o && acc_o[DATA_W-1:16] == '0));

  // R4: split sizes write both halves
  a_r4_split_write: assert property (@(posedge clk) disable iff (rst)
    (done_o && size_q != OPSZ_B) |-> (acc_we_o && dreg_we_o));

  // R5: carry and overflow agree, and track a non-zero high half
  a_r5_flags_agree: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cf_o == of_o));

  a_r5_flag_high_half: assert property (@(posedge clk) disable iff (rst)
    (done_o && size_q != OPSZ_B) |-> (cf_o == (dreg_o != '0)));

  // R9: mask is empty outside done
  a_r9_mask_idle: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> (flags_vld_o == '0));

  // R11: results hold between pulses
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(rst)) |-> ($stable(acc_o) && $stable(dreg_o) && $stable(cf_o)));

endmodule

// File: rtl/mul_unsigned_unit.sv
module mul_unsigned_unit
  import mul_pkg::*;
#(
  parameter int DATA_W = MAX_W,
  localparam int CW    = $clog2(DATA_W + 1),
  localparam int PW    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        size_sel_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] dreg_o,
  output logic              acc_we_o,
  output logic              dreg_we_o,
  output logic              cf_o,
  output logic              of_o,
  output logic [FLG_N-1:0]  flags_vld_o,
  output logic              done_o
);

  opsz_e             dec_size;
  logic [CW-1:0]     dec_bits;
  logic [DATA_W-1:0] dec_mask;
  logic              core_fin;
  opsz_e             core_size;
  logic [PW-1:0]     core_prod;

  mul_size_decode #(.DATA_W(DATA_W), .CW(CW)) i_decode (
    .size_sel_i (size_sel_i),
    .wide_i     (wide_i),
    .size_o     (dec_size),
    .bits_o     (dec_bits),
    .mask_o     (dec_mask)
  );

  mul_shift_add_core #(.DATA_W(DATA_W), .CW(CW)) i_core (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .size_i  (dec_size),
    .bits_i  (dec_bits),
    .mask_i  (dec_mask),
    .acc_i   (acc_i),
    .src_i   (src_i),
    .fin_o   (core_fin),
    .size_o  (core_size),
    .prod_o  (core_prod)
  );

  mul_result_pack #(.DATA_W(DATA_W)) i_pack (
    .clk         (clk),
    .rst         (rst),
    .fin_i       (core_fin),
    .size_i      (core_size),
    .prod_i      (core_prod),
    .acc_o       (acc_o),
    .dreg_o      (dreg_o),
    .acc_we_o    (acc_we_o),
    .dreg_we_o   (dreg_we_o),
    .cf_o        (cf_o),
    .of_o        (of_o),
    .flags_vld_o (flags_vld_o),
    .done_o      (done_o)
  );

  // R10: no completion pulse in the cycle after a reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && acc_o == '0 && dreg_o == '0));

endmodule

// File: tb/test_mul_unsigned_unit.sv
`timescale 1ns/100ps
module test_mul_unsigned_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  size_sel_i = 2'b00;
  logic        wide_i = 1'b0;
  logic [63:0] acc_i = '0;
  logic [63:0] src_i = '0;
  logic [63:0] acc_o, dreg_o;
  logic        acc_we_o, dreg_we_o, cf_o, of_o, done_o;
  logic [5:0]  flags_vld_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mul_unsigned_unit i_mul_unsigned_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .size_sel_i(size_sel_i),
    .wide_i(wide_i), .acc_i(acc_i), .src_i(src_i), .acc_o(acc_o),
    .dreg_o(dreg_o), .acc_we_o(acc_we_o), .dreg_we_o(dreg_we_o),
    .cf_o(cf_o), .of_o(of_o), .flags_vld_o(flags_vld_o), .done_o(done_o)
  );

  // {size_sel, wide, acc, src}
  localparam logic [130:0] VEC [12] = '{
    {2'd0, 1'b0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_00FF},
    {2'd0, 1'b0, 64'h0000_0000_0000_0010, 64'h0000_0000_0000_000F},
    {2'd0, 1'b0, 64'hABCD_EF01_2345_6712, 64'hFFFF_FFFF_FFFF_FF03},
    {2'd1, 1'b0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF},
    {2'd1, 1'b0, 64'h5555_0000_AAAA_1234, 64'h7777_0000_0000_0002},
    {2'd2, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002},
    {2'd3, 1'b0, 64'hDEAD_BEEF_8000_0001, 64'hFEED_FACE_0001_0000},
    {2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'd3, 1'b1, 64'h0000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0},
    {2'd0, 1'b1, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0002},
    {2'd3, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002},
    {2'd2, 1'b0, 64'hFFFF_FFFF_0000_1000, 64'hFFFF_FFFF_0000_0100}
  };

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] sel, input logic wide,
                       input logic [63:0] a, input logic [63:0] b,
                       output int w, output logic [63:0] e_acc,
                       output logic [63:0] e_dreg, output logic e_dwe,
                       output logic e_cf);
    logic [63:0]  m;
    logic [127:0] p;
    w = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : (wide ? 64 : 32);
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    p = {64'd0, a & m} * {64'd0, b & m};
    if (w == 8) begin
      e_acc  = {48'd0, p[15:0]};
      e_dreg = '0;
      e_dwe  = 1'b0;
      e_cf   = |p[15:8];
    end else begin
      e_acc  = p[63:0] & m;
      e_dreg = 64'(p >> w) & m;
      e_dwe  = 1'b1;
      e_cf   = (e_dreg != '0);
    end
  endtask

  task automatic launch(input logic [1:0] sel, input logic wide,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    size_sel_i = sel; wide_i = wide; acc_i = a; src_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (done_o !== 1'b1 && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic check_result(input string tag, input logic [1:0] sel,
                              input logic wide, input logic [63:0] a,
                              input logic [63:0] b, input int lat);
    int w; logic [63:0] ea, ed; logic edwe, ecf;
    model(sel, wide, a, b, w, ea, ed, edwe, ecf);
    chk({tag, " R6"}, "latency", 128'(lat), 128'(w + 1));
    chk({tag, " R3/R4 R2"}, "acc_o", {64'd0, acc_o}, {64'd0, ea});
    chk({tag, " R4"}, "dreg_o", {64'd0, dreg_o}, {64'd0, ed});
    chk({tag, " R3"}, "write enables", {126'd0, acc_we_o, dreg_we_o}, {126'd0, 1'b1, edwe});
    chk({tag, " R5"}, "cf/of", {126'd0, cf_o, of_o}, {126'd0, ecf, ecf});
    chk({tag, " R9"}, "flags_vld_o", {122'd0, flags_vld_o}, {122'd0, 6'b100001});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", "outputs after reset",
        {acc_o, dreg_o}, 128'd0);
    chk("R10", "strobes after reset",
        {119'd0, acc_we_o, dreg_we_o, cf_o, of_o, done_o, flags_vld_o[3:0]}, 128'd0);
    rst = 1'b0;

    // R1..R5, R9: vector table
    foreach (VEC[i]) begin
      launch(VEC[i][130:129], VEC[i][128], VEC[i][127:64], VEC[i][63:0]);
      wait_done(lat);
      check_result($sformatf("vec%0d R1", i), VEC[i][130:129], VEC[i][128],
                   VEC[i][127:64], VEC[i][63:0], lat);
    end

    // R6, R11, R9: pulse ends and results hold
    begin
      logic [63:0] ha, hd; logic hc;
      ha = acc_o; hd = dreg_o; hc = cf_o;
      repeat (5) @(negedge clk);
      chk("R6", "done/we after pulse", {125'd0, done_o, acc_we_o, dreg_we_o}, 128'd0);
      chk("R9", "mask after pulse", {122'd0, flags_vld_o}, 128'd0);
      chk("R11", "held results", {acc_o, dreg_o}, {ha, hd});
      chk("R11", "held carry", {127'd0, cf_o}, {127'd0, hc});
    end

    // R7: start strobe while running is ignored
    launch(2'd0, 1'b0, 64'h3, 64'h5);
    @(negedge clk);
    size_sel_i = 2'd1; acc_i = 64'hFFFF; src_i = 64'hFFFF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done(lat);
    check_result("busy R7", 2'd0, 1'b0, 64'h3, 64'h5, lat + 2);
    begin
      int pulses = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (done_o) pulses++;
      end
      chk("R7", "extra done pulses", 128'(pulses), 128'd0);
    end

    // R8: inputs changed after the start edge
    launch(2'd2, 1'b1, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_0F0F_0F0F);
    size_sel_i = 2'd0; wide_i = 1'b0; acc_i = 64'h1; src_i = 64'h1;
    wait_done(lat);
    check_result("capture R8", 2'd2, 1'b1, 64'hFEDC_BA98_7654_3210,
                 64'h0F0F_0F0F_0F0F_0F0F, lat);

    // R10: reset in the middle of an operation
    launch(2'd1, 1'b0, 64'h1234, 64'h5678);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10", "outputs after mid-run reset", {acc_o, dreg_o}, 128'd0);
    begin
      int pulses = 0;
      for (int k = 0; k < 24; k++) begin
        @(negedge clk);
        if (done_o) pulses++;
      end
      chk("R10", "done after abandoned run", 128'(pulses), 128'd0);
    end

    // R1: wide_i with the 16-bit size has no effect
    launch(2'd1, 1'b1, 64'hFFFF_FFFF_0000_8001, 64'hFFFF_FFFF_0000_0003);
    wait_done(lat);
    check_result("wide-ignored R1", 2'd1, 1'b0, 64'h8001, 64'h3, lat);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule